// File: doc/BRIEF.md
# Video Fetch Scanline Synchroniser

This block sits on the cartridge side of a tile-based video generator. It has no access to the generator's dot clock. It watches only the memory read strobe and the two table-select bits of the video address bus. From these it rebuilds the horizontal dot position of the generator. Each line ends with a recognisable burst of nametable-region reads. The block finds that burst, aligns a read counter to it and then advances the counter by one read, which is two dots, for every strobe that follows.

From the tracked position the block derives four outputs:
- an estimate of the dot counter;
- the index of the current fetch slot inside each 8-dot tile group (nametable, attribute, pattern low, pattern high);
- a line strobe that inverts once per line;
- a flag for the sprite-fetch window.

The block also keeps an in-frame flag. The flag is set when the block locks and cleared when the line-end burst stops appearing, for example while rendering is switched off.

A lock state machine has two states.
- `LK_HUNT`: not locked. The dot output reads 0.
- `LK_TRACK`: locked. The read index advances with each strobe.

It has three named transitions.
- `acquire` (HUNT→TRACK): taken when a sync burst is detected.
- `realign` (TRACK→TRACK): taken on a further sync burst. It reloads the index.
- `timeout` (TRACK→HUNT): taken on the read that exceeds two line periods with no sync.

The parameter `RUN_LEN` selects how many consecutive region reads form a sync burst, 3 or 4.

Top module: `vfs_top`

## Requirements
- R1: A read is a region read when `rd_i` is high and `sel_i` = 2'b10 (address bit 13 = 1, bit 12 = 0). A read with any other `sel_i` value, including 2'b11, breaks the run of consecutive region reads. Cycles with `rd_i` low never add to the run and never break it.
- R2: With `RUN_LEN` = 3, the third consecutive region read is a sync. A sync moves the block to tracking, sets `in_frame_o` and loads `dot_o` with 1. A sync while already tracking realigns `dot_o` to 1 from any position.
- R3: With `RUN_LEN` = 4, three consecutive region reads are not a sync. The fourth one is, and it loads `dot_o` with 3.
- R4: While tracking, each read that is not a sync or a timeout advances `dot_o` by 2 (odd values 1 to 339). A read at dot 339 is followed by dot 1. `dot_o` does not change in a cycle with `rd_i` low. On a stream with real line timing, `dot_o` equals the dot of each read from the first sync on.
- R5: `line_tgl_o` inverts exactly when `dot_o` becomes 339, which is read index 169 of the 170 reads in a line. It inverts once per line.
- R6: `slot_o` equals ((`dot_o` − 1) mod 8) / 2. Dots 1, 3, 5 and 7 give slots 0, 1, 2 and 3, and dot 9 gives slot 0 again.
- R7: `spr_win_o` is high only when in frame and `dot_o` / 2 lies in 128..159, that is dot 256..319.
- R8: While tracking, `in_frame_o` stays high through 340 consecutive reads without a sync. The 341st such read clears it, and `dot_o`, `slot_o` and `spr_win_o` then read 0. The next sync sets `in_frame_o` again.
- R9: After reset: `dot_o` = 0, `slot_o` = 0, `line_tgl_o` = 0, `in_frame_o` = 0, `spr_win_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_i | input | 1 | One-cycle pulse per video memory read |
| sel_i | input | 2 | Address bits 13 and 12 of that read |
| dot_o | output | 9 | Estimated dot of the latest read; 0 when not in frame |
| slot_o | output | 2 | Fetch slot inside the 8-dot tile group |
| line_tgl_o | output | 1 | Inverts once per line at dot 339 |
| in_frame_o | output | 1 | High while locked to the line timing |
| spr_win_o | output | 1 | High during the sprite-fetch window |

## Verification
The sync detector is tried with bursts that are broken by a pattern read or by an upper-table read, which separates a true run of region reads from a plain count of them. Gaps with no strobe but a changing address show that only strobed reads take part. A second instance with a four-read burst is driven with the same three- and four-read bursts, which tells the two modes apart. A long stream with real line timing, including the sprite-interval reads that repeat the nametable region, confirms that the lock lands on dot 1 every line and that no false realignment happens mid-line. Long runs of pattern reads probe the line wrap, the sprite window edges and the exact read on which lock is lost.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    // Lock state of the line tracker.
    typedef enum logic [0:0] {
        LK_HUNT  = 1'b0,
        LK_TRACK = 1'b1
    } lock_state_e;

    // Table-select code of the nametable region (address bit 13 set, bit 12 clear).
    localparam logic [1:0] SEL_NAMETABLE = 2'b10;

endpackage

// File: rtl/vfs_run_detect.sv
module vfs_run_detect
    import vfs_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_i,
    input  logic [1:0] sel_i,
    output logic       sync_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic             in_region;
    logic [RUN_W-1:0] run_q;

    assign in_region = (sel_i == SEL_NAMETABLE);

    // Run length of consecutive strobed region reads, saturating at RUN_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (rd_i) begin
            if (!in_region) begin
                run_q <= '0;
            end else if (run_q != RUN_W'(RUN_LEN)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign sync_o = rd_i && in_region && (run_q == RUN_W'(RUN_LEN - 1));

    // R1: the run never grows past its saturation value
    a_r1_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_LEN));

    // R1: a strobed read outside the region empties the run
    a_r1_run_broken: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !in_region) |=> (run_q == '0));

    // R1: without a strobe the run is left alone
    a_r1_run_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(run_q));

endmodule

// File: rtl/vfs_lock_fsm.sv
module vfs_lock_fsm
    import vfs_pkg::*;
#(
    parameter int LOST_LIMIT = 340
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic sync_i,
    output logic locked_o,
    output logic lost_o
);
    localparam int QUIET_W = $clog2(LOST_LIMIT + 1);

    lock_state_e        state_q;
    lock_state_e        state_d;
    logic [QUIET_W-1:0] quiet_q;
    logic               quiet_full;

    assign quiet_full = (quiet_q == QUIET_W'(LOST_LIMIT));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs: acquire, realign, timeout.
    always_comb begin
        state_d = state_q;
        lost_o  = 1'b0;
        unique case (state_q)
            LK_HUNT: begin
                if (sync_i) begin
                    state_d = LK_TRACK;          // acquire
                end
            end
            LK_TRACK: begin
                if (sync_i) begin
                    state_d = LK_TRACK;          // realign
                end else if (rd_i && quiet_full) begin
                    state_d = LK_HUNT;           // timeout
                    lost_o  = 1'b1;
                end
            end
        endcase
    end

    // Reads seen since the last sync while tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (sync_i || state_q != LK_TRACK || lost_o) begin
            quiet_q <= '0;
        end else if (rd_i) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign locked_o = (state_q == LK_TRACK);

    // R8: silence counter stays within its window
    a_r8_quiet_bound: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= QUIET_W'(LOST_LIMIT));

    // R8: a timeout leaves the tracker unlocked
    a_r8_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !locked_o);

    // R2: any sync leaves the tracker locked
    a_r2_sync_locks: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> locked_o);

endmodule

// File: rtl/vfs_dot_track.sv
module vfs_dot_track #(
    parameter int LINE_READS = 170,
    parameter int LOAD_IDX   = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_i,
    input  logic                          sync_i,
    input  logic                          locked_i,
    input  logic                          lost_i,
    output logic [$clog2(LINE_READS)-1:0] idx_o,
    output logic                          line_tgl_o
);
    localparam int IDX_W = $clog2(LINE_READS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_READS - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_next;
    logic             tgl_q;

    assign idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tgl_q <= 1'b0;
        end else if (sync_i) begin
            idx_q <= IDX_W'(LOAD_IDX);
        end else if (lost_i) begin
            idx_q <= '0;
        end else if (rd_i && locked_i) begin
            idx_q <= idx_next;
            if (idx_next == LAST_IDX) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    assign idx_o      = idx_q;
    assign line_tgl_o = tgl_q;

    // R4: read index stays inside one line
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);

    // R5: the line strobe moves only onto the last read of a line
    a_r5_tgl_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_q != $past(tgl_q)) |-> (idx_q == LAST_IDX));

endmodule

// File: rtl/vfs_top.sv
module vfs_top
    import vfs_pkg::*;
#(
    parameter int RUN_LEN      = 3,
    parameter int LINE_READS   = 170,
    parameter int LOST_LINES   = 2,
    parameter int SPR_HALF_LO  = 128,
    parameter int SPR_HALF_HI  = 159
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_i,
    input  logic [1:0]                      sel_i,
    output logic [$clog2(LINE_READS):0]     dot_o,
    output logic [1:0]                      slot_o,
    output logic                            line_tgl_o,
    output logic                            in_frame_o,
    output logic                            spr_win_o
);
    localparam int IDX_W      = $clog2(LINE_READS);
    localparam int DOT_W      = IDX_W + 1;
    localparam int LOST_LIMIT = LOST_LINES * LINE_READS;
    // Burst reads land on dots 337, 339, 1, 3: the last one fixes the loaded index.
    localparam int LOAD_IDX   = RUN_LEN - 3;
    localparam int LOAD_DOT   = 2 * LOAD_IDX + 1;
    localparam int END_DOT    = 2 * LINE_READS - 1;

    logic             sync;
    logic             locked;
    logic             lost;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] half_dot;

    vfs_run_detect #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_i),
        .sel_i  (sel_i),
        .sync_o (sync)
    );

    vfs_lock_fsm #(
        .LOST_LIMIT (LOST_LIMIT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .sync_i   (sync),
        .locked_o (locked),
        .lost_o   (lost)
    );

    vfs_dot_track #(
        .LINE_READS (LINE_READS),
        .LOAD_IDX   (LOAD_IDX)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_i),
        .sync_i     (sync),
        .locked_i   (locked),
        .lost_i     (lost),
        .idx_o      (idx),
        .line_tgl_o (line_tgl_o)
    );

    // Reads fall on odd dots, so the dot is twice the index plus one.
    assign dot_o      = locked ? {idx, 1'b1} : '0;
    assign slot_o     = locked ? idx[1:0] : 2'b00;
    assign in_frame_o = locked;
    assign half_dot   = dot_o[DOT_W-1:1];
    assign spr_win_o  = locked
                      && (half_dot >= IDX_W'(SPR_HALF_LO))
                      && (half_dot <= IDX_W'(SPR_HALF_HI));

    // R2: lock always begins on the load dot
    a_r2_lock_dot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_o) |-> (dot_o == DOT_W'(LOAD_DOT)));

    // R4: no strobe, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(dot_o));

    // R5: the line strobe flips only at the last dot of a line
    a_r5_flip_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tgl_o != $past(line_tgl_o)) |-> (dot_o == DOT_W'(END_DOT)));

    // R7: sprite window needs lock
    a_r7_win_locked: assert property (@(posedge clk) disable iff (!rst_n)
        spr_win_o |-> in_frame_o);

    // R8: unlocked outputs read zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame_o |-> (dot_o == '0 && slot_o == 2'b00));

endmodule

// File: tb/vfs_top_tb.sv
`timescale 1ns/1ps
module vfs_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [8:0] dot, dot4;
    logic [1:0] slot, slot4;
    logic       tgl, tgl4, inf, inf4, spr, spr4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vfs_top u_dut (
        .clk(clk), .rst_n(rst_n), .rd_i(rd), .sel_i(sel),
        .dot_o(dot), .slot_o(slot), .line_tgl_o(tgl),
        .in_frame_o(inf), .spr_win_o(spr)
    );

    vfs_top #(.RUN_LEN(4)) u_dut_m4 (
        .clk(clk), .rst_n(rst_n), .rd_i(rd), .sel_i(sel),
        .dot_o(dot4), .slot_o(slot4), .line_tgl_o(tgl4),
        .in_frame_o(inf4), .spr_win_o(spr4)
    );

    localparam logic [1:0] NT  = 2'b10;
    localparam logic [1:0] PAT = 2'b00;
    localparam logic [1:0] UPR = 2'b11;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd = 1'b0; sel = PAT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] s);
        @(negedge clk);
        rd = 1'b1; sel = s;
        @(negedge clk);
        rd = 1'b0; sel = PAT;
    endtask

    task automatic reads(input logic [1:0] s, input int n);
        for (int i = 0; i < n; i++) do_read(s);
    endtask

    // Table select of the read at a given dot on a real line.
    function automatic logic [1:0] sel_at(input int d);
        if (d >= 337) return NT;
        if (((d - 1) % 8) == 0 || ((d - 1) % 8) == 2) return NT;
        return PAT;
    endfunction

    task automatic t_reset();
        do_reset();
        chk(dot == 0,  "R9 dot after reset", dot, 0);
        chk(slot == 0, "R9 slot after reset", slot, 0);
        chk(tgl == 0,  "R9 line strobe after reset", tgl, 0);
        chk(inf == 0,  "R9 in_frame after reset", inf, 0);
        chk(spr == 0,  "R9 sprite window after reset", spr, 0);
    endtask

    task automatic t_run_broken();
        do_reset();
        do_read(NT); do_read(NT); do_read(PAT); do_read(NT); do_read(NT);
        chk(inf == 0, "R1 pattern read breaks run", inf, 0);
        do_read(NT);
        chk(inf == 1, "R1 fresh run of three syncs", inf, 1);
        do_reset();
        do_read(NT); do_read(NT); do_read(UPR); do_read(NT); do_read(NT);
        chk(inf == 0, "R1 upper table read breaks run", inf, 0);
    endtask

    task automatic t_gap();
        do_reset();
        do_read(NT); do_read(NT);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sel = (i % 2) ? UPR : PAT;
        end
        chk(inf == 0, "R1 no strobe no sync", inf, 0);
        do_read(NT);
        chk(inf == 1, "R1 unstrobed cycles keep run", inf, 1);
        chk(dot == 1, "R2 dot after sync", dot, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sel = PAT;
        end
        chk(dot == 1, "R4 dot holds without strobe", dot, 1);
    endtask

    task automatic t_sync_advance();
        do_reset();
        reads(NT, 3);
        chk(inf == 1,  "R2 in_frame set", inf, 1);
        chk(dot == 1,  "R2 dot loaded", dot, 1);
        chk(slot == 0, "R6 slot at dot 1", slot, 0);
        for (int k = 1; k <= 4; k++) begin
            do_read(PAT);
            chk(dot == 1 + 2 * k, "R4 dot advances by two", dot, 1 + 2 * k);
            chk(slot == (k % 4), "R6 slot sequence", slot, k % 4);
        end
    endtask

    task automatic t_wrap();
        logic t0;
        do_reset();
        reads(NT, 3);
        t0 = tgl;
        reads(PAT, 167);
        chk(dot == 335, "R4 dot before line end", dot, 335);
        do_read(PAT);
        chk(dot == 337 && tgl == t0, "R5 no flip at 337", tgl, t0);
        do_read(PAT);
        chk(dot == 339, "R4 dot at line end", dot, 339);
        chk(tgl != t0, "R5 flip at 339", tgl, !t0);
        do_read(PAT);
        chk(dot == 1, "R4 wrap to dot 1", dot, 1);
        chk(tgl != t0, "R5 steady after wrap", tgl, !t0);
        reads(PAT, 169);
        chk(dot == 339 && tgl == t0, "R5 second flip one line later", tgl, t0);
    endtask

    task automatic t_spr();
        do_reset();
        reads(NT, 3);
        reads(PAT, 127);
        chk(dot == 255 && spr == 0, "R7 off at 255", spr, 0);
        do_read(PAT);
        chk(dot == 257 && spr == 1, "R7 on at 257", spr, 1);
        reads(PAT, 31);
        chk(dot == 319 && spr == 1, "R7 on at 319", spr, 1);
        do_read(PAT);
        chk(dot == 321 && spr == 0, "R7 off at 321", spr, 0);
    endtask

    task automatic t_timeout();
        do_reset();
        reads(NT, 3);
        reads(PAT, 340);
        chk(inf == 1, "R8 still locked after 340 reads", inf, 1);
        do_read(PAT);
        chk(inf == 0, "R8 lock lost on 341st read", inf, 0);
        chk(dot == 0 && slot == 0 && spr == 0, "R8 outputs zero when lost", dot, 0);
        reads(NT, 3);
        chk(inf == 1 && dot == 1, "R8 relock after loss", dot, 1);
    endtask

    task automatic t_resync();
        do_reset();
        reads(NT, 3);
        reads(PAT, 20);
        chk(dot == 41, "R4 dot mid line", dot, 41);
        reads(NT, 3);
        chk(dot == 1 && inf == 1, "R2 realign mid line", dot, 1);
    endtask

    task automatic t_mode4();
        do_reset();
        reads(NT, 3);
        chk(inf4 == 0, "R3 three reads not enough", inf4, 0);
        chk(inf == 1, "R2 three-read instance locked", inf, 1);
        do_read(NT);
        chk(inf4 == 1, "R3 fourth read syncs", inf4, 1);
        chk(dot4 == 3, "R3 dot loaded with 3", dot4, 3);
    endtask

    task automatic t_real_lines();
        do_reset();
        for (int ln = 0; ln < 4; ln++) begin
            int bad = 0;
            int bad4 = 0;
            int last_bad = 0;
            for (int d = 1; d <= 339; d += 2) begin
                do_read(sel_at(d));
                if (ln >= 1 && dot != d) begin bad++; last_bad = dot; end
                if (ln >= 2 && dot4 != d) bad4++;
            end
            if (ln >= 1) chk(bad == 0, "R4 dot follows real line", last_bad, 0);
            if (ln >= 2) chk(bad4 == 0, "R3 four-read mode follows real line", bad4, 0);
        end
        chk(inf == 1, "R2 locked on real stream", inf, 1);
    endtask

    initial begin
        t_reset();
        t_run_broken();
        t_gap();
        t_sync_advance();
        t_wrap();
        t_spr();
        t_timeout();
        t_resync();
        t_mode4();
        t_real_lines();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule